// File: doc/BRIEF.md
# Multi-output video timing generator

This block produces the raster timing for progressive video from a single pixel-clock timebase. A pixel counter walks across each line and a line counter walks down each field. From those two counters the block derives an active-video flag and four sync pairs. Each pair has one horizontal and one vertical sync, and each pair has its own edge positions, so every downstream video path can be shifted to cancel its own pipeline latency.

The block is configured over a simple 32-bit register bus with single-cycle writes and combinational reads. The same bus gives a soft restart and field-start interrupts, each with its own status and mask bits. Successive fields alternate between a top and a bottom field. The bottom field has its own vertical-sync and window words, which software normally loads with copies of the top-field words. Field length is programmed in half-lines. Vertical sync edges take effect at a programmable pixel within their line, not at pixel 0.

Top module: `vid_timing_gen`

## Requirements
- R1: While running, the pixel position counts 0 to LEN-1 and then returns to 0, where LEN is the line-length register at offset 0x08. A LEN of 0 or 1 keeps the pixel at 0.
- R2: A field holds HALF/2 lines numbered from 1, where HALF is the half-line register at offset 0x0C and HALF/2 is its bits [16:1]. After the last line the counter returns to line 1, and the field alternates between top and bottom. The first field after a restart is top.
- R3: Sync output k has its register group at 0xC0 + 0x20*k, and word +0x00 holds the horizontal sync. hsync_o[k] is high while the pixel lies in [bits 15:0, bits 31:16] inclusive. When the end is below the start, the pulse wraps through pixel 0. The output shows the counter position of the previous clock.
- R4: vsync_o[k] is high from the raster position (line from bits 15:0 of the line word, pixel from bits 15:0 of the offset word) through (bits 31:16 of both words) inclusive, in raster order. When the end comes before the start, the pulse wraps across the field boundary. The latency is the same as for R3.
- R5: The top field uses line word +0x04 and offset word +0x0C, and the bottom field uses +0x08 and +0x10. For the window, the top field uses 0x40 (start) and 0x44 (stop), and the bottom field uses 0x48 and 0x4C.
- R6: active_o is high when the line lies within [start bits 31:16, stop bits 31:16] and the pixel lies within [start bits 15:0, stop bits 15:0]. Both bounds are inclusive, and the latency is one clock.
- R7: Each time the counters sit at line 1, pixel 0 while running, a status bit at 0x78 is set one clock later. Bit 1 is set for a top field and bit 0 for a bottom field.
- R8: Writing ones to 0x7C clears those status bits, and zero bits leave status unchanged. Writing to 0x8C sets mask bits, writing to 0x88 clears them, and the mask reads back at both offsets. irq_o is the OR of (status AND mask).
- R9: A write to 0x10 with bit 0 set puts the counters at line 1, pixel 0, top field on the next clock. A write to 0x10 with bit 0 clear has no effect.
- R10: Mode register 0x00 set to 0 runs the counters, and any other value freezes them. Mode resets to 1, and all other configuration resets to 0.
- R11: reg_rdata_o returns, in the same cycle, the register at reg_addr_i: mode, line length, half-lines, window, status, mask and every sync word.
- R12: While reset is asserted, every sync output, active_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| active_o | output | 1 | Active-video window flag |
| hsync_o | output | NUM_SYNC | Horizontal sync per output |
| vsync_o | output | NUM_SYNC | Vertical sync per output |
| irq_o | output | 1 | Masked field-start interrupt |

## Verification
The bench builds the block with its default parameters: four sync outputs and 16-bit counters. It then programs very short rasters of 10 to 20 pixels and 4 to 8 lines, so that line wraps, field wraps and the top/bottom alternation all occur within a few hundred cycles. Each output is given a different pixel shift, and the bottom-field words differ from the top-field words. This exposes a mix-up between outputs or between fields, and it also exercises pulses that wrap across a line end and across a field end. The interrupt sequence then runs on a 40-cycle field, so both field events and the masking are seen.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned REG_AW = 10;

  localparam logic [REG_AW-1:0] A_MODE      = 10'h000;
  localparam logic [REG_AW-1:0] A_LINE_LEN  = 10'h008;
  localparam logic [REG_AW-1:0] A_HALF_LN   = 10'h00C;
  localparam logic [REG_AW-1:0] A_RESTART   = 10'h010;
  localparam logic [REG_AW-1:0] A_WIN_BASE  = 10'h040;
  localparam logic [REG_AW-1:0] A_IRQ_STAT  = 10'h078;
  localparam logic [REG_AW-1:0] A_IRQ_CLR   = 10'h07C;
  localparam logic [REG_AW-1:0] A_MASK_CLR  = 10'h088;
  localparam logic [REG_AW-1:0] A_MASK_SET  = 10'h08C;
  localparam logic [REG_AW-1:0] A_SYNC_BASE = 10'h0C0;
  localparam int unsigned SYNC_STRIDE = 32;

  localparam int unsigned IRQ_BOT = 0;
  localparam int unsigned IRQ_TOP = 1;

  // index 0 = top field, 1 = bottom field
  typedef struct packed {
    logic [31:0]       hs;
    logic [1:0][31:0]  vl;
    logic [1:0][31:0]  vo;
  } sync_cfg_t;

  function automatic logic [REG_AW-1:0] sync_addr(input int unsigned k, input int unsigned w);
    return A_SYNC_BASE + REG_AW'(k * SYNC_STRIDE + w * 4);
  endfunction

  // inclusive span, wraps when e < s
  function automatic logic in_span(input logic [31:0] p, input logic [31:0] s, input logic [31:0] e);
    if (s <= e) return (p >= s) && (p <= e);
    return (p >= s) || (p <= e);
  endfunction
endpackage

// File: rtl/vtg_timebase.sv
module vtg_timebase
  import vtg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [CW-1:0] line_len_i,
  input  logic [CW-1:0] lines_i,
  output logic [CW-1:0] pix_o,
  output logic [CW-1:0] line_o,
  output logic          field_o,
  output logic          sof_o
);
  logic [CW-1:0] pix_q, line_q;
  logic          field_q;
  logic          pix_wrap, line_wrap;

  assign pix_wrap  = ((CW+1)'(pix_q) + (CW+1)'(1)) >= (CW+1)'(line_len_i);
  assign line_wrap = line_q >= lines_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= '0;
      line_q  <= CW'(1);
      field_q <= 1'b0;
    end else if (restart_i) begin
      pix_q   <= '0;
      line_q  <= CW'(1);
      field_q <= 1'b0;
    end else if (run_i) begin
      if (pix_wrap) begin
        pix_q <= '0;
        if (line_wrap) begin
          line_q  <= CW'(1);
          field_q <= ~field_q;
        end else begin
          line_q <= line_q + CW'(1);
        end
      end else begin
        pix_q <= pix_q + CW'(1);
      end
    end
  end

  assign pix_o   = pix_q;
  assign line_o  = line_q;
  assign field_o = field_q;
  assign sof_o   = run_i && (pix_q == '0) && (line_q == CW'(1));

  a_r1_pix_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (pix_q == '0) || (pix_q == $past(pix_q) + CW'(1)));
  a_r2_line_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q != '0);
  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pix_q == '0) && (line_q == CW'(1)) && !field_q);
  a_r10_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(pix_q) && $stable(line_q) && $stable(field_q));
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned NUM_SYNC = 4,
  parameter int unsigned CW       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              sof_i,
  input  logic              field_i,
  output logic              run_o,
  output logic              restart_o,
  output logic [CW-1:0]     line_len_o,
  output logic [CW-1:0]     lines_o,
  output logic [3:0][31:0]  win_o,
  output sync_cfg_t         sync_o [NUM_SYNC],
  output logic              irq_o
);
  logic [31:0]     mode_q, len_q, half_q;
  logic [3:0][31:0] win_q;
  sync_cfg_t       sync_q [NUM_SYNC];
  logic [1:0]      stat_q, mask_q, stat_set, stat_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 32'd1;
      len_q  <= '0;
      half_q <= '0;
      win_q  <= '0;
      mask_q <= '0;
      for (int k = 0; k < NUM_SYNC; k++) sync_q[k] <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_MODE:      mode_q <= wdata_i;
        A_LINE_LEN:  len_q  <= wdata_i;
        A_HALF_LN:   half_q <= wdata_i;
        A_MASK_SET:  mask_q <= mask_q | wdata_i[1:0];
        A_MASK_CLR:  mask_q <= mask_q & ~wdata_i[1:0];
        default: ;
      endcase
      for (int w = 0; w < 4; w++)
        if (addr_i == A_WIN_BASE + REG_AW'(4 * w)) win_q[w] <= wdata_i;
      for (int k = 0; k < NUM_SYNC; k++) begin
        if (addr_i == sync_addr(k, 0)) sync_q[k].hs    <= wdata_i;
        if (addr_i == sync_addr(k, 1)) sync_q[k].vl[0] <= wdata_i;
        if (addr_i == sync_addr(k, 2)) sync_q[k].vl[1] <= wdata_i;
        if (addr_i == sync_addr(k, 3)) sync_q[k].vo[0] <= wdata_i;
        if (addr_i == sync_addr(k, 4)) sync_q[k].vo[1] <= wdata_i;
      end
    end
  end

  // set beats clear in the same cycle so no field event is lost
  assign stat_set = sof_i ? (field_i ? 2'b01 : 2'b10) : 2'b00;
  assign stat_clr = (wr_i && addr_i == A_IRQ_CLR) ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE:      rdata_o = mode_q;
      A_LINE_LEN:  rdata_o = len_q;
      A_HALF_LN:   rdata_o = half_q;
      A_IRQ_STAT:  rdata_o = {30'd0, stat_q};
      A_MASK_SET,
      A_MASK_CLR:  rdata_o = {30'd0, mask_q};
      default: ;
    endcase
    for (int w = 0; w < 4; w++)
      if (addr_i == A_WIN_BASE + REG_AW'(4 * w)) rdata_o = win_q[w];
    for (int k = 0; k < NUM_SYNC; k++) begin
      if (addr_i == sync_addr(k, 0)) rdata_o = sync_q[k].hs;
      if (addr_i == sync_addr(k, 1)) rdata_o = sync_q[k].vl[0];
      if (addr_i == sync_addr(k, 2)) rdata_o = sync_q[k].vl[1];
      if (addr_i == sync_addr(k, 3)) rdata_o = sync_q[k].vo[0];
      if (addr_i == sync_addr(k, 4)) rdata_o = sync_q[k].vo[1];
    end
  end

  assign run_o      = (mode_q == '0);
  assign restart_o  = wr_i && (addr_i == A_RESTART) && wdata_i[0];
  assign line_len_o = len_q[CW-1:0];
  assign lines_o    = half_q[CW:1];
  assign win_o      = win_q;
  assign irq_o      = |(stat_q & mask_q);
  for (genvar k = 0; k < NUM_SYNC; k++) begin : g_cfg
    assign sync_o[k] = sync_q[k];
  end

  a_r7_top_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !field_i) |=> stat_q[IRQ_TOP]);
  a_r7_bot_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && field_i) |=> stat_q[IRQ_BOT]);
  a_r8_w1c_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_IRQ_CLR && wdata_i[IRQ_TOP] && !(sof_i && !field_i)) |=> !stat_q[IRQ_TOP]);
  a_r8_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MASK_SET && wdata_i[IRQ_BOT]) |=> mask_q[IRQ_BOT]);
endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out
  import vtg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] pix_i,
  input  logic [CW-1:0] line_i,
  input  logic          field_i,
  input  sync_cfg_t     cfg_i,
  output logic          hsync_o,
  output logic          vsync_o
);
  logic [15:0] pix16, line16;
  logic [31:0] vpos, vbeg, vend;
  logic        hs_d, vs_d;

  assign pix16  = 16'(pix_i);
  assign line16 = 16'(line_i);
  assign vpos   = {line16, pix16};
  assign vbeg   = {cfg_i.vl[field_i][15:0],  cfg_i.vo[field_i][15:0]};
  assign vend   = {cfg_i.vl[field_i][31:16], cfg_i.vo[field_i][31:16]};
  assign hs_d   = in_span({16'd0, pix16}, {16'd0, cfg_i.hs[15:0]}, {16'd0, cfg_i.hs[31:16]});
  assign vs_d   = in_span(vpos, vbeg, vend);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      hsync_o <= hs_d;
      vsync_o <= vs_d;
    end
  end
endmodule

// File: rtl/vtg_window.sv
module vtg_window #(
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    pix_i,
  input  logic [CW-1:0]    line_i,
  input  logic             field_i,
  input  logic [3:0][31:0] win_i,
  output logic             active_o
);
  logic [31:0] ws, we;
  logic [15:0] pix16, line16;
  logic        act_d;

  assign ws     = field_i ? win_i[2] : win_i[0];
  assign we     = field_i ? win_i[3] : win_i[1];
  assign pix16  = 16'(pix_i);
  assign line16 = 16'(line_i);
  assign act_d  = (line16 >= ws[31:16]) && (line16 <= we[31:16]) &&
                  (pix16  >= ws[15:0])  && (pix16  <= we[15:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_o <= 1'b0;
    else         active_o <= act_d;
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned NUM_SYNC = 4,
  parameter int unsigned CW       = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                active_o,
  output logic [NUM_SYNC-1:0] hsync_o,
  output logic [NUM_SYNC-1:0] vsync_o,
  output logic                irq_o
);
  logic             run, restart, field, sof;
  logic [CW-1:0]    line_len, lines, pix, line;
  logic [3:0][31:0] win;
  sync_cfg_t        sync_cfg [NUM_SYNC];

  vtg_regs #(.NUM_SYNC(NUM_SYNC), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .sof_i(sof), .field_i(field),
    .run_o(run), .restart_o(restart), .line_len_o(line_len), .lines_o(lines),
    .win_o(win), .sync_o(sync_cfg), .irq_o
  );

  vtg_timebase #(.CW(CW)) u_tb (
    .clk_i, .rst_ni, .run_i(run), .restart_i(restart),
    .line_len_i(line_len), .lines_i(lines),
    .pix_o(pix), .line_o(line), .field_o(field), .sof_o(sof)
  );

  vtg_window #(.CW(CW)) u_win (
    .clk_i, .rst_ni, .pix_i(pix), .line_i(line), .field_i(field),
    .win_i(win), .active_o
  );

  for (genvar k = 0; k < NUM_SYNC; k++) begin : g_sync
    vtg_sync_out #(.CW(CW)) u_sync (
      .clk_i, .rst_ni, .pix_i(pix), .line_i(line), .field_i(field),
      .cfg_i(sync_cfg[k]), .hsync_o(hsync_o[k]), .vsync_o(vsync_o[k])
    );
  end
endmodule

// File: tb/tb_vid_timing_gen.sv
`timescale 1ns/1ps
module tb_vid_timing_gen;
  localparam int NS = 4;

  typedef struct packed {
    logic [15:0] len, lines, hs_s, hs_e, vl_s, vl_e, vo_s, vo_e, ls, le, ps, pe, exp_hs;
  } vec_t;

  // last column: expected hsync-high cycles per line on output 0
  localparam vec_t VEC [4] = '{
    '{16'd16, 16'd6, 16'd0, 16'd3, 16'd1, 16'd2, 16'd0, 16'd0, 16'd2, 16'd5, 16'd4,  16'd13, 16'd4},
    '{16'd12, 16'd5, 16'd9, 16'd2, 16'd5, 16'd1, 16'd7, 16'd7, 16'd1, 16'd5, 16'd0,  16'd11, 16'd6},
    '{16'd20, 16'd8, 16'd5, 16'd5, 16'd3, 16'd3, 16'd2, 16'd10,16'd3, 16'd3, 16'd19, 16'd19, 16'd1},
    '{16'd10, 16'd4, 16'd0, 16'd9, 16'd4, 16'd1, 16'd8, 16'd2, 16'd1, 16'd4, 16'd0,  16'd0,  16'd10}
  };

  logic clk_i = 0, rst_ni = 0, reg_wr_i = 0;
  logic [9:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic active_o, irq_o;
  logic [NS-1:0] hsync_o, vsync_o;

  vid_timing_gen #(.NUM_SYNC(NS), .CW(16)) dut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit chk_en = 0, done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit span(input logic [31:0] p, input logic [31:0] s, input logic [31:0] e);
    if (s <= e) return (p >= s) && (p <= e);
    return (p >= s) || (p <= e);
  endfunction

  // reference model built from the requirements, snooping the bus
  logic [31:0] m_mode, m_len, m_half, ws, we;
  logic [31:0] m_win [4];
  logic [31:0] m_h [NS];
  logic [31:0] m_vl [NS][2];
  logic [31:0] m_vo [NS][2];
  logic [15:0] m_pix, m_line;
  logic        m_fld;
  logic [NS-1:0] e_hs, e_vs;
  logic        e_act;
  int          off;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_mode = 1; m_len = 0; m_half = 0; m_pix = 0; m_line = 1; m_fld = 0;
      e_hs = '0; e_vs = '0; e_act = 0;
      for (int i = 0; i < 4; i++) m_win[i] = 0;
      for (int k = 0; k < NS; k++) begin
        m_h[k] = 0; m_vl[k][0] = 0; m_vl[k][1] = 0; m_vo[k][0] = 0; m_vo[k][1] = 0;
      end
    end else begin
      for (int k = 0; k < NS; k++) begin
        e_hs[k] = span({16'd0, m_pix}, {16'd0, m_h[k][15:0]}, {16'd0, m_h[k][31:16]});
        e_vs[k] = span({m_line, m_pix}, {m_vl[k][m_fld][15:0], m_vo[k][m_fld][15:0]},
                       {m_vl[k][m_fld][31:16], m_vo[k][m_fld][31:16]});
      end
      ws = m_win[m_fld ? 2 : 0];
      we = m_win[m_fld ? 3 : 1];
      e_act = (m_line >= ws[31:16]) && (m_line <= we[31:16]) && (m_pix >= ws[15:0]) && (m_pix <= we[15:0]);
      if (reg_wr_i && reg_addr_i == 10'h010 && reg_wdata_i[0]) begin
        m_pix = 0; m_line = 1; m_fld = 0;
      end else if (m_mode == 0) begin
        if (32'(m_pix) + 1 >= m_len) begin
          m_pix = 0;
          if (32'(m_line) >= {16'd0, m_half[16:1]}) begin m_line = 1; m_fld = ~m_fld; end
          else m_line = m_line + 1;
        end else m_pix = m_pix + 1;
      end
      if (reg_wr_i) begin
        case (reg_addr_i)
          10'h000: m_mode = reg_wdata_i;
          10'h008: m_len = reg_wdata_i;
          10'h00C: m_half = reg_wdata_i;
          10'h040: m_win[0] = reg_wdata_i;
          10'h044: m_win[1] = reg_wdata_i;
          10'h048: m_win[2] = reg_wdata_i;
          10'h04C: m_win[3] = reg_wdata_i;
          default: if (reg_addr_i >= 10'h0C0 && reg_addr_i < 10'h0C0 + NS * 32) begin
            off = int'(reg_addr_i) - 'hC0;
            case (off % 32)
              0:  m_h[off / 32] = reg_wdata_i;
              4:  m_vl[off / 32][0] = reg_wdata_i;
              8:  m_vl[off / 32][1] = reg_wdata_i;
              12: m_vo[off / 32][0] = reg_wdata_i;
              16: m_vo[off / 32][1] = reg_wdata_i;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  string ctx = "R1";
  always @(negedge clk_i) begin
    if (chk_en) begin
      chk({ctx, "/R3 hsync"}, 32'(hsync_o), 32'(e_hs));
      chk({ctx, "/R4 vsync"}, 32'(vsync_o), 32'(e_vs));
      chk({ctx, "/R6 active"}, 32'(active_o), 32'(e_act));
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    logic [NS-1:0] hold;
    int cnt;
    vec_t v;
    repeat (3) @(negedge clk_i);
    // R12: outputs low during reset
    chk("R12 hsync", 32'(hsync_o), 0);
    chk("R12 vsync", 32'(vsync_o), 0);
    chk("R12 active", 32'(active_o), 0);
    chk("R12 irq", 32'(irq_o), 0);
    rst_ni = 1;
    chk_en = 1;
    rd(10'h000, rv); chk("R10 mode reset value", rv, 1);
    rd(10'h078, rv); chk("R7 status reset", rv, 0);

    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      ctx = "R1/R2";
      wr(10'h000, 1);
      wr(10'h008, 32'(v.len));
      wr(10'h00C, 32'(v.lines) * 2);
      wr(10'h040, {v.ls, v.ps});
      wr(10'h044, {v.le, v.pe});
      wr(10'h048, {v.ls, v.ps + 16'd1});
      wr(10'h04C, {v.le, v.pe});
      for (int k = 0; k < NS; k++) begin
        wr(10'h0C0 + 10'(k * 32), {(v.hs_e + 16'(k)) % v.len, (v.hs_s + 16'(k)) % v.len});
        wr(10'h0C4 + 10'(k * 32), {v.vl_e, v.vl_s});
        wr(10'h0C8 + 10'(k * 32), {v.vl_e, v.vl_s});
        wr(10'h0CC + 10'(k * 32), {(v.vo_e + 16'(k)) % v.len, (v.vo_s + 16'(k)) % v.len});
        wr(10'h0D0 + 10'(k * 32), {(v.vo_e + 16'(k + 1)) % v.len, (v.vo_s + 16'(k + 1)) % v.len});
      end
      ctx = "R5";
      wr(10'h000, 0);
      wr(10'h010, 1);
      repeat (2 * int'(v.len) * int'(v.lines) + 5) @(negedge clk_i);
      cnt = 0;
      for (int c = 0; c < int'(v.len); c++) begin
        @(negedge clk_i);
        if (hsync_o[0]) cnt++;
      end
      chk("R3 hsync width per line", cnt, 32'(v.exp_hs));
      ctx = "R9";
      wr(10'h010, 0);
      repeat (7) @(negedge clk_i);
      wr(10'h010, 1);
      repeat (3 * int'(v.len)) @(negedge clk_i);
      ctx = "R10";
      wr(10'h000, 5);
      @(negedge clk_i);
      hold = hsync_o | (vsync_o << 0);
      repeat (10) @(negedge clk_i);
      chk("R10 outputs frozen", 32'(hsync_o), 32'(hold));
      wr(10'h000, 0);
      repeat (int'(v.len) + 3) @(negedge clk_i);
    end

    // R11 readback
    rd(10'h008, rv); chk("R11 line length", rv, 10);
    rd(10'h00C, rv); chk("R11 half lines", rv, 8);
    rd(10'h130, rv); chk("R11 output 3 bottom offset", rv, {16'd6, 16'd2});
    rd(10'h048, rv); chk("R11 window bottom start", rv, {16'd1, 16'd1});

    // interrupts on a 40-cycle field
    ctx = "R7/R8";
    wr(10'h000, 1);
    wr(10'h088, 3);
    wr(10'h07C, 3);
    wr(10'h010, 1);
    wr(10'h08C, 2);
    rd(10'h088, rv); chk("R8 mask readback", rv, 2);
    wr(10'h000, 0);
    rd(10'h078, rv); chk("R7 top event bit1", rv, 2);
    chk("R8 irq on top", 32'(irq_o), 1);
    wr(10'h07C, 2);
    rd(10'h078, rv); chk("R8 w1c cleared", rv, 0);
    chk("R8 irq low after clear", 32'(irq_o), 0);
    repeat (40) @(negedge clk_i);
    rd(10'h078, rv); chk("R7 bottom event bit0", rv, 1);
    chk("R8 bottom masked", 32'(irq_o), 0);
    wr(10'h08C, 1);
    #1 chk("R8 irq after mask set", 32'(irq_o), 1);
    wr(10'h07C, 0);
    rd(10'h078, rv); chk("R8 zero write keeps status", rv, 1);
    wr(10'h088, 1);
    #1 chk("R8 irq after mask clear", 32'(irq_o), 0);

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule